// File: doc/BRIEF.md
# Interrupt state register bank

This block holds the per-source interrupt state of a vectored interrupt controller: an enable bit, a pending bit, an active bit and a priority value for each of up to 256 sources. The default build has 240 sources. Software reaches the state through a single-cycle word bus. Writes take effect at the next clock edge, and read data is a combinational function of the address and the stored state. An arbiter next to the block sees all of the state at once through flat vectors.

The enable bits and the pending bits each have two address windows. Writing to one window can only set bits, and writing to the other can only clear bits. Software therefore never needs a read-modify-write sequence that could race with hardware.

Pending bits are set in three ways: by a rising edge on a source's interrupt line, by a write to a set window, or by writing a source number to a trigger register. When the arbiter takes a source, that source moves from pending to active. When the arbiter retires a source, its active bit is cleared.

Top module: `irq_state_bank`

## Requirements
- R1: After reset, every enable, pending, active and priority value reads as zero, and all arbiter-facing vectors are zero.
- R2: Enable set window, at byte offsets 0x000 to 0x01C: word k, bit b stands for source 32k+b. Writing a 1 to a bit sets that enable, and writing a 0 leaves it unchanged. Reading word k of this window, or of the enable clear window, returns the current enables.
- R3: Enable clear window, at byte offsets 0x080 to 0x09C, with the same word and bit layout: writing a 1 clears that enable, and writing a 0 leaves it unchanged.
- R4: Pending state has a set window at 0x100 to 0x11C and a clear window at 0x180 to 0x19C. Both use the layout and the set-only and clear-only behaviour of R2 and R3, and reads of either window return the pending bits.
- R5: The active window, at 0x200 to 0x21C with the R2 layout, is read-only. Writes to it change nothing.
- R6: A 0-to-1 change on a source's interrupt line sets that source's pending bit at the next edge. A line that stays high does not set the bit again after software has cleared it.
- R7: A take strobe with a source number below the source count clears that source's pending bit and sets its active bit at the same edge. If a set event for the same source arrives in that cycle, the pending bit stays 1.
- R8: A retire strobe with a source number below the source count clears that source's active bit.
- R9: Priority bytes start at 0x300. Source n sits in the word at 0x300 + 4*(n/4), in byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)). Only the upper four bits of each byte are kept, and the lower four bits read as zero.
- R10: Writing a value n to the trigger register at 0xE00 sets pending bit n when n is below the source count. A larger value is ignored, and the register reads as zero.
- R11: Reserved addresses, and bits or bytes for sources at or above the source count, read as zero and ignore writes. Take and retire strobes that name such sources do nothing.
- R12: The enable, pending, active and priority vectors seen by the arbiter, and the bus read data, always match the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_line | input | 240 | Interrupt lines, one per source |
| take_valid | input | 1 | Arbiter takes the source given by take_id |
| take_id | input | 8 | Source being taken |
| retire_valid | input | 1 | Arbiter retires the source given by retire_id |
| retire_id | input | 8 | Source being retired |
| src_enable | output | 240 | Enable bits |
| src_pending | output | 240 | Pending bits |
| src_active | output | 240 | Active bits |
| src_prio | output | 960 | Four-bit priority for each source, source n at bits 4n+3:4n |

## Verification
The bench goes after the cases where two writers meet on the same pending bit. A take in the same cycle as a trigger write for the same source must leave both the pending bit and the active bit set; a design that lets the clear win would lose that interrupt. An interrupt line held high after software clears its pending bit must not pend it again; a level-sensitive design would keep re-pending that source. The bench also probes the part-filled top word and the top priority word, the trigger register with values just inside and just outside the source range, and writes of zeros to the set windows. A design that misplaced the boundary would expose phantom sources, and one that treated a written 0 as a clear would lose enables.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   localparam int WORD_BITS  = 32;
   localparam int BANK_WORDS = 8;
   localparam int MAX_SRC    = WORD_BITS * BANK_WORDS;
   localparam int LANES      = WORD_BITS / 8;

   typedef enum logic [2:0] {
      WIN_NONE,
      WIN_EN_SET,
      WIN_EN_CLR,
      WIN_PD_SET,
      WIN_PD_CLR,
      WIN_ACT,
      WIN_PRIO,
      WIN_TRIG
   } win_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output logic [2:0]        bank_word,
   output logic [5:0]        prio_word
);

   logic hi_ok;

   if (ADDR_W < 12) begin : g_bad_addr
      $error("irq_addr_decode: ADDR_W must be at least 12");
   end

   if (ADDR_W > 12) begin : g_hi
      assign hi_ok = (addr[ADDR_W-1:12] == '0);
   end else begin : g_nohi
      assign hi_ok = 1'b1;
   end

   assign bank_word = addr[4:2];
   assign prio_word = addr[7:2];

   always_comb begin
      win = WIN_NONE;
      if (hi_ok) begin
         if (addr[11:8] == 4'h3) begin
            win = WIN_PRIO;
         end else if (addr[11:10] == 2'b00 && addr[6:5] == 2'b00) begin
            case (addr[9:7])
               3'd0:    win = WIN_EN_SET;
               3'd1:    win = WIN_EN_CLR;
               3'd2:    win = WIN_PD_SET;
               3'd3:    win = WIN_PD_CLR;
               3'd4:    win = WIN_ACT;
               default: win = WIN_NONE;
            endcase
         end else if (addr[11:2] == 10'h380) begin
            win = WIN_TRIG;
         end
      end
   end

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int N = 240
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line_i,
   output logic [N-1:0] rise_o
);

   logic [N-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= line_i;
   end

   assign rise_o = line_i & ~line_q;

endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store
   import irq_bank_pkg::*;
#(
   parameter int N         = 240,
   parameter int PRIO_BITS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [5:0]             word,
   input  logic [WORD_BITS-1:0]   wdata,
   output logic [N*PRIO_BITS-1:0] prio_flat,
   output logic [WORD_BITS-1:0]   rd_word
);

   localparam int PAD = 8 - PRIO_BITS;

   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_pb
      $error("irq_prio_store: PRIO_BITS must lie in 1..8");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      localparam int LANE = i % LANES;
      localparam int WIDX = i / LANES;
      logic [PRIO_BITS-1:0] prio_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q <= '0;
         end else if (wr_en && word == 6'(WIDX)) begin
            prio_q <= wdata[8*LANE+PAD +: PRIO_BITS];
         end
      end

      assign prio_flat[i*PRIO_BITS +: PRIO_BITS] = prio_q;
   end

   always_comb begin
      rd_word = '0;
      for (int l = 0; l < LANES; l++) begin
         int src;
         src = int'(word) * LANES + l;
         if (src < N) begin
            rd_word[8*l+PAD +: PRIO_BITS] = prio_flat[src*PRIO_BITS +: PRIO_BITS];
         end
      end
   end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
   import irq_bank_pkg::*;
#(
   parameter int N         = 240,
   parameter int PRIO_BITS = 4,
   parameter int ADDR_W    = 12,
   parameter int ID_W      = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic [N-1:0]           irq_line,
   input  logic                   take_valid,
   input  logic [ID_W-1:0]        take_id,
   input  logic                   retire_valid,
   input  logic [ID_W-1:0]        retire_id,
   output logic [N-1:0]           src_enable,
   output logic [N-1:0]           src_pending,
   output logic [N-1:0]           src_active,
   output logic [N*PRIO_BITS-1:0] src_prio
);

   localparam logic [7:0]  LOW_BYTE = 8'((1 << (8 - PRIO_BITS)) - 1);
   localparam logic [31:0] LOW_MASK = {LANES{LOW_BYTE}};

   if (N < 1 || N > MAX_SRC) begin : g_bad_n
      $error("irq_state_bank: N must lie in 1..256");
   end
   if ((1 << ID_W) < N) begin : g_bad_id
      $error("irq_state_bank: ID_W too narrow for N");
   end

   win_e       win;
   logic [2:0] bank_word;
   logic [5:0] prio_word;

   irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr      (bus_addr),
      .win       (win),
      .bank_word (bank_word),
      .prio_word (prio_word)
   );

   logic [N-1:0] hw_rise;

   irq_edge_detect #(.N(N)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (irq_line),
      .rise_o (hw_rise)
   );

   logic [31:0] prio_rd;

   irq_prio_store #(.N(N), .PRIO_BITS(PRIO_BITS)) u_prio (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr && win == WIN_PRIO),
      .word      (prio_word),
      .wdata     (bus_wdata),
      .prio_flat (src_prio),
      .rd_word   (prio_rd)
   );

   // per-source set and clear masks
   logic [N-1:0] en_set, en_clr, pd_set, pd_clr, trig_hit, take_hit, ret_hit;

   for (genvar i = 0; i < N; i++) begin : g_mask
      localparam int W = i / WORD_BITS;
      localparam int B = i % WORD_BITS;
      logic word_hit;
      assign word_hit    = bus_wr && bank_word == 3'(W) && bus_wdata[B];
      assign en_set[i]   = word_hit && win == WIN_EN_SET;
      assign en_clr[i]   = word_hit && win == WIN_EN_CLR;
      assign pd_set[i]   = word_hit && win == WIN_PD_SET;
      assign pd_clr[i]   = word_hit && win == WIN_PD_CLR;
      assign trig_hit[i] = bus_wr && win == WIN_TRIG && bus_wdata == 32'(i);
      assign take_hit[i] = take_valid && take_id == ID_W'(i);
      assign ret_hit[i]  = retire_valid && retire_id == ID_W'(i);
   end

   logic [N-1:0] en_q, pd_q, act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pd_q  <= '0;
         act_q <= '0;
      end else begin
         en_q  <= (en_q | en_set) & ~en_clr;
         // any set source wins over a clear in the same cycle
         pd_q  <= (pd_q & ~(pd_clr | take_hit)) | pd_set | trig_hit | hw_rise;
         act_q <= (act_q & ~ret_hit) | take_hit;
      end
   end

   assign src_enable  = en_q;
   assign src_pending = pd_q;
   assign src_active  = act_q;

   // read path
   logic [MAX_SRC-1:0] en_pad, pd_pad, act_pad;

   always_comb begin
      en_pad  = '0;
      pd_pad  = '0;
      act_pad = '0;
      en_pad[N-1:0]  = en_q;
      pd_pad[N-1:0]  = pd_q;
      act_pad[N-1:0] = act_q;
   end

   always_comb begin
      case (win)
         WIN_EN_SET, WIN_EN_CLR: bus_rdata = en_pad[bank_word*WORD_BITS +: WORD_BITS];
         WIN_PD_SET, WIN_PD_CLR: bus_rdata = pd_pad[bank_word*WORD_BITS +: WORD_BITS];
         WIN_ACT:                bus_rdata = act_pad[bank_word*WORD_BITS +: WORD_BITS];
         WIN_PRIO:               bus_rdata = prio_rd;
         default:                bus_rdata = '0;
      endcase
   end

   // assertions
   assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(src_enable));

   assert_hw_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_rise != '0) |=> ((src_pending & $past(hw_rise)) == $past(hw_rise)));

   assert_take_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && int'(take_id) < N) |=> src_active[$past(take_id)]);

   assert_act_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_valid && !retire_valid) |=> $stable(src_active));

   assert_prio_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (win == WIN_PRIO) |-> ((bus_rdata & LOW_MASK) == '0));

   assert_resv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (win == WIN_NONE || win == WIN_TRIG) |-> (bus_rdata == '0));

endmodule

// File: tb/irq_state_bank_bench.sv
`timescale 1ns/1ps
module irq_state_bank_bench;

   localparam int NS = 240;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] irq_line = '0;
   logic          take_valid = 1'b0;
   logic [7:0]    take_id = '0;
   logic          retire_valid = 1'b0;
   logic [7:0]    retire_id = '0;
   logic [NS-1:0] src_enable, src_pending, src_active;
   logic [NS*4-1:0] src_prio;

   int vectors = 0;
   int fails = 0;

   always #4 clk = ~clk;

   irq_state_bank u_irq_state_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line),
      .take_valid(take_valid), .take_id(take_id),
      .retire_valid(retire_valid), .retire_id(retire_id),
      .src_enable(src_enable), .src_pending(src_pending),
      .src_active(src_active), .src_prio(src_prio)
   );

   // behavioural reference model
   bit m_en[NS], m_pd[NS], m_ac[NS], m_prev[NS];
   int m_pr[NS];

   function automatic bit in_range(int aa, int lo, int span);
      return aa >= lo && aa < lo + span;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_en[i] = 0; m_pd[i] = 0; m_ac[i] = 0; m_prev[i] = 0; m_pr[i] = 0;
         end
      end else begin
         int aa;
         aa = int'({bus_addr[11:2], 2'b00});
         for (int i = 0; i < NS; i++) begin
            bit wb, setp, clrp;
            wb = bus_wr && bus_wdata[i % 32];
            if (wb && in_range(aa, 'h000, 32) && (aa >> 2) == i / 32) m_en[i] = 1;
            if (wb && in_range(aa, 'h080, 32) && ((aa - 'h080) >> 2) == i / 32) m_en[i] = 0;
            setp = (irq_line[i] && !m_prev[i])
                || (wb && in_range(aa, 'h100, 32) && ((aa - 'h100) >> 2) == i / 32)
                || (bus_wr && aa == 'hE00 && bus_wdata == 32'(i));
            clrp = (wb && in_range(aa, 'h180, 32) && ((aa - 'h180) >> 2) == i / 32)
                || (take_valid && int'(take_id) == i);
            if (setp) m_pd[i] = 1;
            else if (clrp) m_pd[i] = 0;
            if (take_valid && int'(take_id) == i) m_ac[i] = 1;
            else if (retire_valid && int'(retire_id) == i) m_ac[i] = 0;
            if (bus_wr && in_range(aa, 'h300, 256) && (aa - 'h300) == (i & ~3))
               m_pr[i] = int'(bus_wdata[8*(i%4) +: 8]) & 'hF0;
            m_prev[i] = irq_line[i];
         end
      end
   end

   function automatic logic [31:0] model_rd(logic [11:0] a);
      logic [31:0] r;
      int aa, s;
      r = '0;
      aa = int'({a[11:2], 2'b00});
      for (int b = 0; b < 32; b++) begin
         if (in_range(aa, 'h000, 32)) begin s = (aa >> 2) * 32 + b; if (s < NS) r[b] = m_en[s]; end
         if (in_range(aa, 'h080, 32)) begin s = ((aa - 'h080) >> 2) * 32 + b; if (s < NS) r[b] = m_en[s]; end
         if (in_range(aa, 'h100, 32)) begin s = ((aa - 'h100) >> 2) * 32 + b; if (s < NS) r[b] = m_pd[s]; end
         if (in_range(aa, 'h180, 32)) begin s = ((aa - 'h180) >> 2) * 32 + b; if (s < NS) r[b] = m_pd[s]; end
         if (in_range(aa, 'h200, 32)) begin s = ((aa - 'h200) >> 2) * 32 + b; if (s < NS) r[b] = m_ac[s]; end
      end
      if (in_range(aa, 'h300, 256)) begin
         for (int l = 0; l < 4; l++) begin
            s = aa - 'h300 + l;
            if (s < NS) r[8*l +: 8] = 8'(m_pr[s]);
         end
      end
      return r;
   endfunction

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      bit bad;
      logic [31:0] exp_rd;
      bad = 0;
      for (int i = 0; i < NS; i++) begin
         if (src_enable[i] !== m_en[i] || src_pending[i] !== m_pd[i] ||
             src_active[i] !== m_ac[i] || int'(src_prio[i*4 +: 4]) != (m_pr[i] >> 4))
            bad = 1;
      end
      exp_rd = model_rd(bus_addr);
      vectors++;
      if (bad || bus_rdata !== exp_rd) begin
         fails++;
         $display("FAIL R12 t=%0t addr=%h rdata act=%h exp=%h state_mismatch=%0d",
                  $time, bus_addr, bus_rdata, exp_rd, bad);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      bus_addr = a;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
      #1;
   endtask

   task automatic take(logic [7:0] id);
      take_valid = 1'b1; take_id = id;
      @(negedge clk); #1;
      take_valid = 1'b0;
   endtask

   task automatic retire(logic [7:0] id);
      retire_valid = 1'b1; retire_id = id;
      @(negedge clk); #1;
      retire_valid = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      rd(12'h000, 32'h0, "R1 enable");
      rd(12'h100, 32'h0, "R1 pending");
      rd(12'h200, 32'h0, "R1 active");
      rd(12'h300, 32'h0, "R1 prio");
      // R2 / R3: enable windows
      wr(12'h000, 32'hA5A5_0001);
      rd(12'h000, 32'hA5A5_0001, "R2 set view");
      rd(12'h080, 32'hA5A5_0001, "R2 clear view read");
      wr(12'h000, 32'h0);
      rd(12'h000, 32'hA5A5_0001, "R2 zeros no effect");
      wr(12'h080, 32'h0000_0001);
      rd(12'h000, 32'hA5A5_0000, "R3 clear");
      chk("R12 enable port bit16", 32'(src_enable[16]), 32'h1);
      wr(12'h01C, 32'hFFFF_FFFF);
      rd(12'h01C, 32'h0000_FFFF, "R11 top word");
      // R4: pending windows
      wr(12'h104, 32'h0000_00F0);
      rd(12'h184, 32'h0000_00F0, "R4 set");
      wr(12'h184, 32'h0000_0010);
      rd(12'h104, 32'h0000_00E0, "R4 clear");
      // R5: active is read-only
      wr(12'h200, 32'hFFFF_FFFF);
      rd(12'h200, 32'h0, "R5 read-only");
      // R6: hardware edge
      irq_line[40] = 1'b1;
      rd(12'h104, 32'h0000_01E0, "R6 edge pends");
      wr(12'h184, 32'h0000_0100);
      rd(12'h104, 32'h0000_00E0, "R6 held level no re-pend");
      irq_line[40] = 1'b0;
      // R7: take
      wr(12'h100, 32'h0000_0020);
      take(8'd5);
      rd(12'h100, 32'h0, "R7 take clears pending");
      rd(12'h200, 32'h0000_0020, "R7 take sets active");
      bus_wr = 1'b1; bus_addr = 12'hE00; bus_wdata = 32'd6;
      take_valid = 1'b1; take_id = 8'd6;
      @(negedge clk); #1;
      bus_wr = 1'b0; take_valid = 1'b0;
      rd(12'h100, 32'h0000_0040, "R7 set beats take");
      rd(12'h200, 32'h0000_0060, "R7 active with set");
      // R8: retire
      retire(8'd5);
      rd(12'h200, 32'h0000_0040, "R8 retire");
      chk("R12 active port bit6", 32'(src_active[6]), 32'h1);
      // R9: priority bytes
      wr(12'h300, 32'h1234_5678);
      rd(12'h300, 32'h1030_5070, "R9 upper nibbles");
      chk("R9 prio port src0", 32'(src_prio[3:0]), 32'h7);
      chk("R9 prio port src3", 32'(src_prio[15:12]), 32'h1);
      wr(12'h3EC, 32'hFFFF_FFFF);
      rd(12'h3EC, 32'hF0F0_F0F0, "R9 last word");
      wr(12'h3F0, 32'hFFFF_FFFF);
      rd(12'h3F0, 32'h0, "R11 beyond sources");
      // R10: trigger
      wr(12'hE00, 32'd239);
      rd(12'h11C, 32'h0000_8000, "R10 trigger 239");
      wr(12'hE00, 32'd240);
      rd(12'h11C, 32'h0000_8000, "R10 trigger 240 ignored");
      rd(12'hE00, 32'h0, "R10 reads zero");
      chk("R12 pending port bit239", 32'(src_pending[239]), 32'h1);
      // R11: reserved space and out-of-range ids
      wr(12'h040, 32'hFFFF_FFFF);
      rd(12'h040, 32'h0, "R11 gap");
      rd(12'h800, 32'h0, "R11 high gap");
      take(8'd250);
      rd(12'h21C, 32'h0, "R11 take out of range");
      // mixed traffic, checked every cycle against the model
      for (int c = 0; c < 4000; c++) begin
         int pick;
         pick = $urandom_range(0, 9);
         case (pick)
            0: bus_addr = 12'(32'h000 + 4 * $urandom_range(0, 7));
            1: bus_addr = 12'(32'h080 + 4 * $urandom_range(0, 7));
            2: bus_addr = 12'(32'h100 + 4 * $urandom_range(0, 7));
            3: bus_addr = 12'(32'h180 + 4 * $urandom_range(0, 7));
            4: bus_addr = 12'(32'h200 + 4 * $urandom_range(0, 7));
            5, 6: bus_addr = 12'(32'h300 + 4 * $urandom_range(0, 63));
            7: bus_addr = 12'hE00;
            8: bus_addr = 12'h040;
            default: bus_addr = 12'(4 * $urandom_range(0, 1023));
         endcase
         bus_wr = ($urandom_range(0, 1) == 1);
         bus_wdata = (pick == 7) ? 32'($urandom_range(0, 255)) : $urandom;
         irq_line[$urandom_range(0, NS - 1)] ^= 1'b1;
         take_valid = ($urandom_range(0, 3) == 0);
         take_id = 8'($urandom_range(0, 255));
         retire_valid = ($urandom_range(0, 3) == 0);
         retire_id = 8'($urandom_range(0, 255));
         @(negedge clk); #1;
      end
      bus_wr = 1'b0; take_valid = 1'b0; retire_valid = 1'b0;
      @(negedge clk); #1;
      summary();
   end

endmodule